// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B, and can move data between them either straight through or by way of two storage registers. Each direction has its own register and its own capture strobe: the A-to-B register samples what is on bus A, and the B-to-A register samples what is on bus B. A per-direction select chooses whether the opposite bus shows the live value or the stored one. A per-direction drive enable decides whether that bus is driven at all. The A-to-B enable is active high. The B-to-A enable is active low, so the idle setting of both pins isolates the buses.

Each bus is split into an input vector, an output vector and an output-enable vector, so a pad ring or an on-chip tri-state wrapper can combine them. Both registers run on one system clock. A capture happens on a rising clock edge where the direction's capture strobe is high. A parameter picks an inverting or a non-inverting data path. The registers always hold the true bus value, and any inversion is applied where data leaves toward the other bus. When a bus is being driven by the block, the register on that side samples the value the block drives rather than the pin input. This lets one bus's data be loaded into both registers in a single edge.

The block moves plain parallel words under pin-level control, not a stream of transfers. It therefore has no valid/ready handshake and no back-pressure: every pin is a level or a strobe sampled on the clock.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst_n` is low, both registers are held at zero. With stored data selected, the outputs then read 0x00 when INVERT=0 and 0xFF when INVERT=1.
- R2: `b_oe` is all ones when `ab_en` is 1 and all zeros when `ab_en` is 0, in the same cycle.
- R3: `a_oe` is all ones when `ba_en_n` is 0 and all zeros when `ba_en_n` is 1, in the same cycle.
- R4: With `ab_sel` = 0, `b_out` shows the live `a_in` (after the transfer function of R10) in the same cycle, whatever the value of `b_oe`.
- R5: With `ab_sel` = 1, `b_out` shows the A-to-B register (after R10), and `a_in` has no effect on `b_out`.
- R6: `ba_sel` chooses for `a_out` in the same way: 0 selects live `b_in`, 1 selects the B-to-A register, and in each case R10 applies.
- R7: On a rising edge with `ab_cap` = 1, the A-to-B register loads the bus-A value, whatever the enables are set to. With `ab_cap` = 0 it holds its value.
- R8: On a rising edge with `ba_cap` = 1, the B-to-A register loads the bus-B value, whatever the enables are set to. With `ba_cap` = 0 it holds its value.
- R9: The bus value that a register samples is the block's own output while that bus is driven (`a_out` when `a_oe` is set, `b_out` when `b_oe` is set), and the pin input otherwise. So one bus's data can be stored in both registers in one edge.
- R10: With INVERT=1 the transfer function is the bitwise complement. With INVERT=0 it is the identity. The registers always store the uncomplemented bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; captures on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| a_in | input | W | Value present on bus A |
| a_out | output | W | Value the block offers to bus A |
| a_oe | output | W | Drive enable for bus A, one bit per line |
| b_in | input | W | Value present on bus B |
| b_out | output | W | Value the block offers to bus B |
| b_oe | output | W | Drive enable for bus B, one bit per line |
| ab_en | input | 1 | Drive bus B when 1 |
| ba_en_n | input | 1 | Drive bus A when 0 |
| ab_sel | input | 1 | Source for bus B: 0 live A, 1 stored A-to-B |
| ba_sel | input | 1 | Source for bus A: 0 live B, 1 stored B-to-A |
| ab_cap | input | 1 | Load the A-to-B register on this clock edge |
| ba_cap | input | 1 | Load the B-to-A register on this clock edge |

## Verification
The bench builds two copies of the block, one with INVERT=0 and one with INVERT=1, and drives both from the same stimulus. Any difference between them must therefore come from the transfer function alone. Running both copies covers the case where a register samples a driven bus: with inversion, storing one bus's data into both registers leaves complementary words in the two registers. The twice-inverted return trip can only be checked in the inverting copy. The bench steps through directed cases for isolation, live transfers, storage in both registers and fully stored driving, then runs a long run of random enables, selects and strobes.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

  // Source choice for the word sent toward the opposite bus
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

endpackage

// File: rtl/bus_xcvr_capture.sv
// One direction's storage register with a capture strobe
module bus_xcvr_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] bus_val,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (cap) begin
      q <= bus_val;
    end
  end

endmodule

// File: rtl/bus_xcvr_path.sv
// Output side of one direction: live/stored choice, optional inversion, drive enable
module bus_xcvr_path
  import bus_xcvr_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         en,
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] dout,
  output logic [W-1:0] oe
);

  src_sel_e     src;
  logic [W-1:0] picked;

  assign src = src_sel_e'(sel);

  always_comb begin
    unique case (src)
      SRC_STORED: picked = stored;
      default:    picked = live;
    endcase
  end

  generate
    if (INVERT) begin : g_inv
      assign dout = ~picked;
    end else begin : g_thru
      assign dout = picked;
    end
  endgenerate

  assign oe = {W{en}};

endmodule

// File: rtl/bus_xcvr_reg.sv
// Registered bidirectional bus transceiver between buses A and B
module bus_xcvr_reg
  import bus_xcvr_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         ab_en,
  input  logic         ba_en_n,
  input  logic         ab_sel,
  input  logic         ba_sel,
  input  logic         ab_cap,
  input  logic         ba_cap
);

  logic [W-1:0] q_ab;
  logic [W-1:0] q_ba;
  logic [W-1:0] a_seen;
  logic [W-1:0] b_seen;
  logic         drive_a;
  logic         drive_b;

  assign drive_a = ~ba_en_n;
  assign drive_b = ab_en;

  // A driven bus carries the block's own word; otherwise the pin value
  assign a_seen = drive_a ? a_out : a_in;
  assign b_seen = drive_b ? b_out : b_in;

  bus_xcvr_capture #(.W(W)) u_ab_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (ab_cap),
    .bus_val (a_seen),
    .q       (q_ab)
  );

  bus_xcvr_capture #(.W(W)) u_ba_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (ba_cap),
    .bus_val (b_seen),
    .q       (q_ba)
  );

  // Live paths take the pin inputs, so no combinational loop forms
  bus_xcvr_path #(.W(W), .INVERT(INVERT)) u_to_b (
    .en     (drive_b),
    .sel    (ab_sel),
    .live   (a_in),
    .stored (q_ab),
    .dout   (b_out),
    .oe     (b_oe)
  );

  bus_xcvr_path #(.W(W), .INVERT(INVERT)) u_to_a (
    .en     (drive_a),
    .sel    (ba_sel),
    .live   (b_in),
    .stored (q_ba),
    .dout   (a_out),
    .oe     (a_oe)
  );

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe,
  input logic         ab_en,
  input logic         ba_en_n,
  input logic         ab_sel,
  input logic         ab_cap,
  input logic         ba_cap,
  input logic [W-1:0] q_ab,
  input logic [W-1:0] q_ba
);

  // R2
  b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_en |-> (b_oe == '0));

  // R2
  b_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_en |-> (&b_oe));

  // R3
  a_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ba_en_n |-> (a_oe == '0));

  // R5
  b_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_sel |-> (b_out == (INVERT ? ~q_ab : q_ab)));

  // R7
  ab_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_cap |=> (q_ab == $past(a_oe[0] ? a_out : a_in)));

  // R7
  ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_cap |=> $stable(q_ab));

  // R8
  ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ba_cap |=> $stable(q_ba));

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W), .INVERT(INVERT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_in    (a_in),
  .a_out   (a_out),
  .a_oe    (a_oe),
  .b_out   (b_out),
  .b_oe    (b_oe),
  .ab_en   (ab_en),
  .ba_en_n (ba_en_n),
  .ab_sel  (ab_sel),
  .ab_cap  (ab_cap),
  .ba_cap  (ba_cap),
  .q_ab    (q_ab),
  .q_ba    (q_ba)
);

// File: tb/bus_xcvr_reg_bench.sv
module bus_xcvr_reg_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_en = 1'b0, ba_en_n = 1'b1, ab_sel = 1'b0, ba_sel = 1'b0;
  logic ab_cap = 1'b0, ba_cap = 1'b0;

  logic [W-1:0] a_out0, a_oe0, b_out0, b_oe0;
  logic [W-1:0] a_out1, a_oe1, b_out1, b_oe1;

  bus_xcvr_reg #(.W(W), .INVERT(1'b0)) u_bus_xcvr_reg (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out0), .a_oe(a_oe0),
    .b_in(b_in), .b_out(b_out0), .b_oe(b_oe0), .ab_en(ab_en), .ba_en_n(ba_en_n),
    .ab_sel(ab_sel), .ba_sel(ba_sel), .ab_cap(ab_cap), .ba_cap(ba_cap));

  bus_xcvr_reg #(.W(W), .INVERT(1'b1)) u_bus_xcvr_reg_inv (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out1), .a_oe(a_oe1),
    .b_in(b_in), .b_out(b_out1), .b_oe(b_oe1), .ab_en(ab_en), .ba_en_n(ba_en_n),
    .ab_sel(ab_sel), .ba_sel(ba_sel), .ab_cap(ab_cap), .ba_cap(ba_cap));

  typedef struct {
    string        tag;
    logic [W-1:0] ea0, eb0, ea1, eb1, eaoe, eboe;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad = 0;
  logic [W-1:0] mab [2];
  logic [W-1:0] mba [2];

  function automatic logic [W-1:0] xf(input logic [W-1:0] v, input int inv);
    return (inv != 0) ? ~v : v;
  endfunction

  function automatic exp_t predict(input string tag);
    exp_t e;
    e.tag  = tag;
    e.eb0  = xf(ab_sel ? mab[0] : a_in, 0);
    e.ea0  = xf(ba_sel ? mba[0] : b_in, 0);
    e.eb1  = xf(ab_sel ? mab[1] : a_in, 1);
    e.ea1  = xf(ba_sel ? mba[1] : b_in, 1);
    e.eboe = {W{ab_en}};
    e.eaoe = {W{~ba_en_n}};
    return e;
  endfunction

  // Driver: advance the reference registers for the edge just passed, apply, push
  task automatic step(input string tag, input logic [W-1:0] ai, input logic [W-1:0] bi,
                      input logic abe, input logic baen, input logic abs, input logic bas,
                      input logic abc, input logic bac);
    @(posedge clk);
    #1;
    for (int v = 0; v < 2; v++) begin
      logic [W-1:0] oa, ob, na, nb;
      oa = xf(ba_sel ? mba[v] : b_in, v);
      ob = xf(ab_sel ? mab[v] : a_in, v);
      na = !ba_en_n ? oa : a_in;   // R9
      nb = ab_en ? ob : b_in;      // R9
      if (ab_cap) mab[v] = na;
      if (ba_cap) mba[v] = nb;
    end
    a_in = ai; b_in = bi; ab_en = abe; ba_en_n = baen;
    ab_sel = abs; ba_sel = bas; ab_cap = abc; ba_cap = bac;
    exp_q.push_back(predict(tag));
  endtask

  task automatic cmp(input string tag, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: pop one item per cycle and compare away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      cmp(e.tag, "a_out plain", a_out0, e.ea0);
      cmp(e.tag, "b_out plain", b_out0, e.eb0);
      cmp(e.tag, "a_out inv",   a_out1, e.ea1);
      cmp(e.tag, "b_out inv",   b_out1, e.eb1);
      cmp(e.tag, "a_oe",        a_oe0,  e.eaoe);
      cmp(e.tag, "b_oe",        b_oe0,  e.eboe);
      cmp(e.tag, "a_oe inv",    a_oe1,  e.eaoe);
      cmp(e.tag, "b_oe inv",    b_oe1,  e.eboe);
    end
  end

  initial begin
    #(8 * 20000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mab[0] = '0; mab[1] = '0; mba[0] = '0; mba[1] = '0;
    // R1: stored words under reset, both buses driven
    a_in = 8'h5A; b_in = 8'hC3; ab_en = 1'b1; ba_en_n = 1'b0; ab_sel = 1'b1; ba_sel = 1'b1;
    exp_q.push_back(predict("R1"));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R2 R3: isolation, with captures still allowed (R7 R8)
    step("R2_R3 isolate", 8'h12, 8'h34, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    // R5 R6: show what was captured during isolation
    step("R5_R6 stored", 8'hFF, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R7 R8: no strobe, inputs change, registers hold
    step("R7_R8 hold", 8'hA5, 8'h5A, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R4 R10: live A to B
    step("R4 live", 8'h0F, 8'h99, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R4 live2", 8'h80, 8'h99, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R6 R10: live B to A
    step("R6 live", 8'h77, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R9: A data into both registers while B is driven from live A
    step("R9 storeA", 8'hE1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R9 showA", 8'h00, 8'h66, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R9: B data into both registers while A is driven from live B
    step("R9 storeB", 8'h11, 8'h4B, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R9 showB", 8'h22, 8'h33, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R7 R8: capture while fully driven from stored data (loads its own words)
    step("R7_R8 selfload", 8'hAA, 8'h55, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    step("R7_R8 after", 8'hAA, 8'h55, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R5: a_in has no effect on stored B output
    step("R5 ignoreA", 8'h3F, 8'h55, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    // Random mix of all controls
    for (int i = 0; i < 300; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      step("R2_R10 random", W'($urandom), W'($urandom), r[0], r[1], r[2], r[3], r[4], r[5]);
    end
    step("R7_R8 drain", 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk); @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule